// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of device request lines and a CPU core. It collects a number of maskable, level-sensitive request lines and one non-maskable line. From the requests that are pending and enabled it picks the most urgent one, and it raises a single request toward the CPU when that pick outranks the work already in service. The CPU answers at an instruction boundary by pulsing an acknowledge. On the cycle after a valid acknowledge, the controller drives a programmable vector number, which the CPU uses as an index into its handler table.

The controller keeps the level now in service in an internal register, so only strictly more urgent requests can interrupt a running handler. Each acknowledge pushes the level that was in service onto a small stack. Each interrupt-return pulse from the CPU pops that stack, so requests of lower urgency can be taken again once the handler exits. The stack has one entry per level, so nesting can go all the way from idle up to the non-maskable source.

Priority levels are numbered in binary:
- Level 0 is the non-maskable line.
- Level n+1 is maskable line n.
- Level NUM_LINES+1 means idle, with nothing in service.

A lower number is more urgent.

Top module: `prio_vec_intc`

## Requirements
- R1: After a synchronous active-low reset, all of the following hold:
  - `cpu_irq`, `vec_valid` and `vec_out` are 0.
  - `cur_level` is NUM_LINES+1 (idle).
  - The mask register is 0, so every maskable line is disabled.
  - The vector of line n is n+1.
- R2: `cpu_prio` reports, in binary, the level of the most urgent enabled pending source. Among the maskable lines the lowest-numbered line wins. When no source is pending and enabled, `cpu_prio` is NUM_LINES+1.
- R3: A write with `cfg_addr` 0 loads `cfg_wdata[NUM_LINES-1:0]` into the mask register. A mask bit of 1 enables its line. A line whose mask bit is 0 never raises `cpu_irq`.
- R4: The non-maskable line has level 0, no mask bit can disable it, and it outranks every maskable line.
- R5: `cpu_irq` is high exactly when the pending level is numerically below `cur_level`. A request of equal or lower urgency than the level in service stays pending without raising `cpu_irq`.
- R6: When `cpu_ack` is high and `cpu_irq` is high at a clock edge, two things happen on the next cycle:
  - `vec_valid` is high for exactly one cycle.
  - `cur_level` takes the acknowledged level.

  An acknowledge while `cpu_irq` is low is ignored.
- R7: `vec_out` is 0 in every cycle in which `vec_valid` is low.
- R8: A write with `cfg_addr` n+1 sets the vector of line n to `cfg_wdata[VEC_W-1:0]`. The non-maskable source always delivers the parameter NMI_VEC, which defaults to 0x80.
- R9: An `cpu_iret` pulse restores `cur_level` to the level that was in service before the most recent unreturned acknowledge. Nesting is supported to a depth of NUM_LINES+1. An `cpu_iret` pulse with nothing in service is ignored.
- R10: The request lines are level-sensitive. If a line drops before it is acknowledged, its request is withdrawn in the same cycle.
- R11: Configuration writes to addresses above NUM_LINES change neither the mask nor any vector.
- R12: When `cpu_iret` and `cpu_ack` arrive in the same cycle, the return is performed and the acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | NUM_LINES | Level-sensitive maskable requests; bit 0 is the most urgent |
| nmi_line | input | 1 | Non-maskable request, level-sensitive |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | 0 selects the mask; n+1 selects the vector of line n |
| cfg_wdata | input | DATA_W | Configuration write data |
| cpu_ack | input | 1 | Acknowledge from the CPU at an instruction boundary |
| cpu_iret | input | 1 | Interrupt-return pulse from the CPU |
| cpu_irq | output | 1 | Request toward the CPU |
| cpu_prio | output | LVL_W | Binary level of the most urgent enabled pending source |
| vec_valid | output | 1 | One-cycle strobe that marks the vector after an acknowledge |
| vec_out | output | VEC_W | Vector number; 0 when not valid |
| cur_level | output | LVL_W | Level now in service |

## Verification
The hardest condition to reach from the ports is a full-depth nest. Every maskable line and then the non-maskable line must each be acknowledged in turn, each taken while the previous handler is still in service. This fills the level stack to its last entry. It is followed by a return for every entry and one extra return on an empty stack. A directed sequence builds this nest one line at a time, going from the least urgent line to the most urgent, and then unwinds it.

Random traffic then mixes the other cases:
- Mask and vector writes, including writes to unused addresses.
- Request lines that drop before they are acknowledged.
- Acknowledges that arrive while no request is raised.
- Acknowledge and return pulses in the same cycle.

A bench-side model of the level stack tracks all of this.

// File: rtl/ivc_pkg.sv
// Package: shared types for the interrupt controller.
// Assumes: nothing; holds only the action encoding used by the top.
package ivc_pkg;

    // What the controller does with the level stack in a cycle.
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_TAKE   = 2'd1,
        ACT_RETURN = 2'd2
    } ivc_act_e;

endpackage

// File: rtl/ivc_cfg_regs.sv
// Module: ivc_cfg_regs
// Holds the mask register and one vector register per maskable line.
// Address 0 selects the mask; address n+1 selects the vector of line n.
// Writes to any other address are dropped.
// Assumes: DATA_W covers both NUM_LINES and VEC_W.
module ivc_cfg_regs #(
    parameter int NUM_LINES = 8,
    parameter int VEC_W     = 8,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    output logic [NUM_LINES-1:0]            mask,
    output logic [NUM_LINES-1:0][VEC_W-1:0] vec_tbl
);

    // Mask register: reset disables every line, address 0 reloads it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (we && addr == '0) begin
            mask <= wdata[NUM_LINES-1:0];
        end
    end

    // One vector register per line, each with its own address.
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_vec
        // Vector of line n: resets to n+1, loaded from address n+1.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_tbl[n] <= VEC_W'(n + 1);
            end else if (we && addr == ADDR_W'(n + 1)) begin
                vec_tbl[n] <= wdata[VEC_W-1:0];
            end
        end
    end

    // A mask write lands on the next cycle.
    a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == '0) |=> mask == $past(wdata[NUM_LINES-1:0]));

    // Writes above the last vector address leave the mask alone.
    a_r11_oob_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr > ADDR_W'(NUM_LINES)) |=> $stable(mask));

    // Writes above the last vector address leave the vectors alone.
    a_r11_oob_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr > ADDR_W'(NUM_LINES)) |=> $stable(vec_tbl));

endmodule

// File: rtl/ivc_prio_pick.sv
// Module: ivc_prio_pick
// Fixed-priority encoder over the non-maskable line and the enabled
// maskable lines. Level 0 is the non-maskable line and level n+1 is line n.
// A lower level is more urgent.
// Assumes: the caller has already applied the mask to the maskable lines.
module ivc_prio_pick #(
    parameter int NUM_LINES = 8,
    parameter int LVL_W     = 4
) (
    input  logic                 nmi,
    input  logic [NUM_LINES-1:0] enabled_lines,
    output logic                 valid,
    output logic [LVL_W-1:0]     level
);

    localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'(NUM_LINES + 1);

    // Scan from the least urgent line upward so the most urgent one wins.
    always_comb begin
        valid = 1'b0;
        level = IDLE_LVL;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (enabled_lines[i]) begin
                valid = 1'b1;
                level = LVL_W'(i + 1);
            end
        end
        if (nmi) begin
            valid = 1'b1;
            level = '0;
        end
    end

endmodule

// File: rtl/ivc_level_stack.sv
// Module: ivc_level_stack
// Holds the level in service and a stack of the levels it interrupted.
// A push saves the current level and installs the new one.
// A pop restores the most recently saved level.
// A pop on an empty stack is ignored.
// Assumes: push and pop are never high together, and each push carries a
// strictly more urgent level, so DEPTH = NUM_LINES+1 is never exceeded.
module ivc_level_stack #(
    parameter int DEPTH = 9,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LVL_W-1:0] push_level,
    input  logic             pop,
    output logic [LVL_W-1:0] cur_level,
    output logic             empty
);

    localparam int               PTR_W    = $clog2(DEPTH + 1);
    localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'(DEPTH);

    logic [PTR_W-1:0] sp;
    logic [LVL_W-1:0] saved [DEPTH];
    logic [LVL_W-1:0] top_level;

    assign empty = (sp == '0);

    // Stack pointer: count up on push, count down on a pop that has an entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (push) begin
            sp <= sp + 1'b1;
        end else if (pop && !empty) begin
            sp <= sp - 1'b1;
        end
    end

    // Stack entries: entry i saves the level in service when sp equals i.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Entry i: reset to idle, written on a push at depth i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                saved[i] <= IDLE_LVL;
            end else if (push && sp == PTR_W'(i)) begin
                saved[i] <= cur_level;
            end
        end
    end

    // Read the entry just below the stack pointer.
    always_comb begin
        top_level = IDLE_LVL;
        for (int i = 0; i < DEPTH; i++) begin
            if (sp == PTR_W'(i + 1)) begin
                top_level = saved[i];
            end
        end
    end

    // Level in service: a push installs the new level, a pop restores the saved one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_level <= IDLE_LVL;
        end else if (push) begin
            cur_level <= push_level;
        end else if (pop && !empty) begin
            cur_level <= top_level;
        end
    end

    // Nesting never runs past the last entry.
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> sp < PTR_W'(DEPTH));

    // Only a strictly more urgent level may be installed.
    a_r5_push_strict: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> push_level < cur_level);

    // A pop that has an entry moves back to a less urgent level.
    a_r9_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> cur_level > $past(cur_level));

    // A pop on an empty stack changes nothing.
    a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> $stable(cur_level));

endmodule

// File: rtl/prio_vec_intc.sv
// Module: prio_vec_intc (top)
// Prioritized, vectored interrupt controller with nesting:
//   - picks the most urgent enabled source;
//   - raises cpu_irq when that source outranks the level in service;
//   - on acknowledge, pushes the level in service and issues the source's
//     vector for one cycle;
//   - on interrupt return, pops back to the saved level.
// Assumes: the CPU pulses cpu_ack and cpu_iret for one cycle each.
// A return in the same cycle as an acknowledge wins, and the acknowledge
// is dropped.
module prio_vec_intc #(
    parameter int                  NUM_LINES = 8,
    parameter int                  VEC_W     = 8,
    parameter logic [VEC_W-1:0]    NMI_VEC   = 8'h80,
    localparam int                 LVL_W     = $clog2(NUM_LINES + 2),
    localparam int                 ADDR_W    = $clog2(NUM_LINES + 1),
    localparam int                 DATA_W    = (NUM_LINES > VEC_W) ? NUM_LINES : VEC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 nmi_line,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic                 cpu_ack,
    input  logic                 cpu_iret,
    output logic                 cpu_irq,
    output logic [LVL_W-1:0]     cpu_prio,
    output logic                 vec_valid,
    output logic [VEC_W-1:0]     vec_out,
    output logic [LVL_W-1:0]     cur_level
);

    import ivc_pkg::*;

    logic [NUM_LINES-1:0]            mask;
    logic [NUM_LINES-1:0][VEC_W-1:0] vec_tbl;
    logic                            cand_valid;
    logic [LVL_W-1:0]                cand_level;
    logic [VEC_W-1:0]                cand_vec;
    logic                            stack_empty;
    ivc_act_e                        act;

    ivc_cfg_regs #(
        .NUM_LINES (NUM_LINES),
        .VEC_W     (VEC_W),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .mask    (mask),
        .vec_tbl (vec_tbl)
    );

    ivc_prio_pick #(
        .NUM_LINES (NUM_LINES),
        .LVL_W     (LVL_W)
    ) u_pick (
        .nmi           (nmi_line),
        .enabled_lines (irq_lines & mask),
        .valid         (cand_valid),
        .level         (cand_level)
    );

    // Request toward the CPU only for a strictly more urgent source.
    assign cpu_irq  = cand_valid && (cand_level < cur_level);
    assign cpu_prio = cand_level;

    // Decide the stack action: a return beats an acknowledge in the same cycle.
    always_comb begin
        act = ACT_IDLE;
        if (cpu_iret) begin
            act = stack_empty ? ACT_IDLE : ACT_RETURN;
        end else if (cpu_ack && cpu_irq) begin
            act = ACT_TAKE;
        end
    end

    ivc_level_stack #(
        .DEPTH (NUM_LINES + 1),
        .LVL_W (LVL_W)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (act == ACT_TAKE),
        .push_level (cand_level),
        .pop        (act == ACT_RETURN),
        .cur_level  (cur_level),
        .empty      (stack_empty)
    );

    // Select the vector of the chosen source: fixed for the non-maskable line.
    always_comb begin
        cand_vec = NMI_VEC;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (cand_level == LVL_W'(i + 1)) begin
                cand_vec = vec_tbl[i];
            end
        end
    end

    // Vector output: driven for one cycle after an accepted acknowledge, else 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else if (act == ACT_TAKE) begin
            vec_valid <= 1'b1;
            vec_out   <= cand_vec;
        end else begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end
    end

    // The vector appears only after an accepted acknowledge with no return.
    a_r6_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(cpu_ack && cpu_irq && !cpu_iret));

    // The vector strobe never lasts more than one cycle.
    a_r6_vec_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid || $past(cpu_ack && cpu_irq && !cpu_iret));

    // The vector lines are quiet while no vector is valid.
    a_r7_vec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> vec_out == '0);

    // The non-maskable line always heads the pick.
    a_r4_nmi_top: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_line |-> cpu_prio == '0);

    // A raised request is always more urgent than the level in service.
    a_r5_irq_strict: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> cpu_prio < cur_level);

    // An accepted acknowledge installs the acknowledged level.
    a_r6_level_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_irq && !cpu_iret) |=> cur_level == $past(cpu_prio));

endmodule

// File: tb/sim_prio_vec_intc.sv
// Bench for prio_vec_intc.
// A reference model of the mask, the vectors and the level stack predicts
// every output in every cycle. Directed cases come first, then seeded random
// traffic.
module sim_prio_vec_intc;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int IDLE       = N + 1;
    localparam int NMI_V      = 8'h80;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] irq_lines;
    logic         nmi_line;
    logic         cfg_we;
    logic [3:0]   cfg_addr;
    logic [7:0]   cfg_wdata;
    logic         cpu_ack;
    logic         cpu_iret;
    logic         cpu_irq;
    logic [3:0]   cpu_prio;
    logic         vec_valid;
    logic [7:0]   vec_out;
    logic [3:0]   cur_level;

    int total = 0;
    int bad   = 0;

    // Reference model state.
    int           m_mask;
    int           m_vec [N];
    int           m_stk [N+1];
    int           m_sp;
    int           m_cur;
    int           e_vv;
    int           e_vec;
    string        ctx = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_vec_intc u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .nmi_line  (nmi_line),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cpu_ack   (cpu_ack),
        .cpu_iret  (cpu_iret),
        .cpu_irq   (cpu_irq),
        .cpu_prio  (cpu_prio),
        .vec_valid (vec_valid),
        .vec_out   (vec_out),
        .cur_level (cur_level)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, ctx, act, exp, $time);
        end
    endtask

    // Expected pending level: non-maskable first, then lowest enabled line.
    function automatic int exp_cand(input logic nmi, input logic [N-1:0] lines, input int msk);
        if (nmi) return 0;
        for (int i = 0; i < N; i++) begin
            if (lines[i] && msk[i]) return i + 1;
        end
        return IDLE;
    endfunction

    function automatic int exp_vec_of(input int lvl);
        if (lvl == 0) return NMI_V;
        return m_vec[lvl-1];
    endfunction

    task automatic model_reset();
        m_mask = 0;
        for (int i = 0; i < N; i++) m_vec[i] = i + 1;
        m_sp  = 0;
        m_cur = IDLE;
        e_vv  = 0;
        e_vec = 0;
    endtask

    // One cycle: inputs are already driven; check, clock, update the model.
    task automatic cycle();
        int cand;
        #1;
        cand = exp_cand(nmi_line, irq_lines, m_mask);
        chk("R2 cpu_prio", int'(cpu_prio), cand);
        chk("R5 cpu_irq", int'(cpu_irq), int'(cand < m_cur));
        chk("R9 cur_level", int'(cur_level), m_cur);
        chk("R6 vec_valid", int'(vec_valid), e_vv);
        if (e_vv != 0) chk("R8 vec_out", int'(vec_out), e_vec);
        else           chk("R7 vec_out idle", int'(vec_out), 0);
        @(posedge clk);
        e_vv  = 0;
        e_vec = 0;
        if (cpu_iret) begin
            if (m_sp > 0) begin
                m_sp--;
                m_cur = m_stk[m_sp];
            end
        end else if (cpu_ack && cand < m_cur) begin
            m_stk[m_sp] = m_cur;
            m_sp++;
            m_cur = cand;
            e_vv  = 1;
            e_vec = exp_vec_of(cand);
        end
        if (cfg_we) begin
            if (cfg_addr == 0) m_mask = int'(cfg_wdata);
            else if (int'(cfg_addr) <= N) m_vec[cfg_addr-1] = int'(cfg_wdata);
        end
        @(negedge clk);
    endtask

    task automatic drive(input logic [N-1:0] l, input logic nmi, input logic ack,
                         input logic iret, input logic we, input int a, input int d);
        irq_lines = l;
        nmi_line  = nmi;
        cpu_ack   = ack;
        cpu_iret  = iret;
        cfg_we    = we;
        cfg_addr  = 4'(a);
        cfg_wdata = 8'(d);
        cycle();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [N-1:0] lines;
        void'($urandom(32'd1234));
        model_reset();
        rst_n = 1'b0;
        irq_lines = '0; nmi_line = 0; cpu_ack = 0; cpu_iret = 0;
        cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        // R1: state held under reset.
        chk("R1 cpu_irq", int'(cpu_irq), 0);
        chk("R1 cur_level", int'(cur_level), IDLE);
        chk("R1 vec_valid", int'(vec_valid), 0);
        chk("R1 vec_out", int'(vec_out), 0);
        rst_n = 1'b1;

        // R3: every line pending but masked, no request; then unmask.
        ctx = "R3";
        drive('1, 0, 1, 0, 0, 0, 0);
        drive('1, 0, 0, 0, 1, 0, 8'h00);
        drive(8'h30, 0, 0, 0, 1, 0, 8'hF0);
        // R10: the request disappears when the line drops before acknowledge.
        ctx = "R10";
        drive(8'h00, 0, 0, 0, 0, 0, 0);
        drive(8'h20, 0, 1, 0, 0, 0, 0);
        drive(8'h20, 0, 0, 0, 0, 0, 0);
        drive(8'h20, 0, 0, 1, 0, 0, 0);
        // R4: the non-maskable line wins with everything masked.
        ctx = "R4";
        drive(8'h00, 0, 0, 0, 1, 0, 8'h00);
        drive(8'hFF, 1, 1, 0, 0, 0, 0);
        drive(8'hFF, 1, 0, 0, 0, 0, 0);
        drive(8'h00, 0, 0, 1, 0, 0, 0);
        // R11: writes above the vector range must not touch mask or vectors.
        ctx = "R11";
        drive(8'h00, 0, 0, 0, 1, 9, 8'hAA);
        drive(8'h00, 0, 0, 0, 1, 15, 8'h55);
        drive(8'h01, 0, 0, 0, 0, 0, 0);
        drive(8'h00, 0, 0, 0, 1, 0, 8'hFF);
        for (int i = 0; i < N; i++) begin
            drive(8'(1 << i), 0, 1, 0, 0, 0, 0);
            drive(8'h00, 0, 0, 1, 0, 0, 0);
        end
        // R8: reprogram vectors and take one line.
        ctx = "R8";
        for (int i = 0; i < N; i++) drive(8'h00, 0, 0, 0, 1, i + 1, 8'h40 + i);
        drive(8'h08, 0, 1, 0, 0, 0, 0);
        drive(8'h00, 0, 0, 1, 0, 0, 0);
        // R9: full-depth nest from least urgent line up to the non-maskable one.
        ctx = "R9 nest";
        lines = '0;
        for (int i = N - 1; i >= 0; i--) begin
            lines[i] = 1'b1;
            drive(lines, 0, 1, 0, 0, 0, 0);
        end
        drive(lines, 1, 1, 0, 0, 0, 0);
        drive(lines, 1, 1, 0, 0, 0, 0);
        for (int i = 0; i < N + 2; i++) drive(8'h00, 0, 0, 1, 0, 0, 0);
        chk("R9 unwound to idle", int'(cur_level), IDLE);
        // R12: return and acknowledge together, the acknowledge is dropped.
        ctx = "R12";
        drive(8'h80, 0, 1, 0, 0, 0, 0);
        drive(8'h01, 0, 1, 1, 0, 0, 0);
        drive(8'h01, 0, 0, 0, 0, 0, 0);
        drive(8'h00, 0, 1, 1, 0, 0, 0);

        // Random traffic.
        ctx = "rand";
        lines = '0;
        for (int c = 0; c < 4000; c++) begin
            logic nmi, ack, iret, we;
            if ($urandom_range(0, 3) == 0) lines = 8'($urandom);
            nmi  = ($urandom_range(0, 31) == 0);
            ack  = ($urandom_range(0, 2) == 0);
            iret = ($urandom_range(0, 4) == 0);
            we   = ($urandom_range(0, 15) == 0);
            drive(lines, nmi, ack, iret, we, $urandom_range(0, 15), $urandom_range(0, 255));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule